// File: doc/BRIEF.md
# Battery-Backed Domain Clock Control

This block holds the control register of a battery-backed clock domain. Software uses it to start a low-speed external crystal oscillator and then polls a ready flag until the oscillator has settled. It also picks one of three sources for the real-time counter clock and gates that clock on. A software reset of the domain returns everything to the unconfigured state. The oscillator start-up is modelled by a cycle counter. The clock-source mux itself is not modelled: the block only produces a tick enable that shows when the selected source is delivering a clock edge.

Writes to the domain register take effect only while a write-unlock bit in a separate power-control register is set. The source-select field takes one nonzero value after each domain reset and holds it until the next domain reset. This prevents a stray write from switching the counter clock while the domain is running.

Top module: `bkup_clk_ctl`

## Requirements
- R1: After `rst_n` is released, `dom_rd`, `pwr_rd` and `rtc_tick` all read 0.
- R2: The write-unlock bit is bit 8 of the power-control register (`wr_dom`=0). It is the only bit of that register that is stored, and all other bits read 0. While it is 0, every write to the domain register (`wr_dom`=1) leaves `dom_rd` unchanged.
- R3: The domain register stores the oscillator enable at bit 0, the oscillator bypass at bit 2 and the tick enable at bit 15, and reads them back at those positions. Unused bits read 0.
- R4: The ready flag at bit 1 is read-only. It reads 1 starting `OSC_START_CYC` clock edges after the edge that wrote oscillator enable to 1, and writing bit 1 has no effect.
- R5: The edge that writes the oscillator enable to 0 also clears the ready flag, and the start-up count restarts from zero.
- R6: The source select is bits 9:8 with the encoding 0 = none, 1 = external crystal, 2 = internal RC, 3 = main clock divided by `HSE_DIV`. Once it is nonzero, writes cannot change it.
- R7: A domain write with bit 16 = 1 clears the oscillator enable, ready flag, bypass, tick enable and source select on that edge, and bit 16 reads 1. While bit 16 is 1, writes change only bit 16. A write with bit 16 = 0 releases the reset, and after that the source select can be written again.
- R8: With the tick enabled and source 1 selected, `rtc_tick` equals the ready flag.
- R9: With the tick enabled and source 2 selected, `rtc_tick` follows the `lsi_ready` input combinationally.
- R10: With the tick enabled and source 3 selected, `rtc_tick` is a one-cycle pulse every `HSE_DIV` cycles. The first pulse is high in the cycle after the `HSE_DIV-1`th edge that follows the enabling write.
- R11: With the tick enable at 0 or source 0 selected, `rtc_tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_dom | input | 1 | Write target: 1 = domain register, 0 = power-control register |
| wr_data | input | 32 | Write data |
| lsi_ready | input | 1 | Internal RC oscillator running indication |
| dom_rd | output | 32 | Domain register contents |
| pwr_rd | output | 32 | Power-control register contents |
| rtc_tick | output | 1 | Tick enable of the selected clock source |

## Verification
Most internal faults appear on `dom_rd` at the next negative edge after the write or count edge that caused them. A source select that changes when it should be locked, a reset bit that fails to clear the fields, and a write accepted while locked all show up there. Start-up counter errors move the ready rise away from exactly `OSC_START_CYC` edges, so the bench samples both sides of that edge. A wrong divider count shows up only on `rtc_tick`, as a first pulse off cycle `HSE_DIV-1` or a wrong number of pulses in four periods.

// File: rtl/bkup_clk_ctl.sv
module bkup_clk_ctl #(
  parameter int OSC_START_CYC = 2048,
  parameter int HSE_DIV       = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_dom,
  input  logic [31:0] wr_data,
  input  logic        lsi_ready,
  output logic [31:0] dom_rd,
  output logic [31:0] pwr_rd,
  output logic        rtc_tick
);

  localparam int CW = $clog2(OSC_START_CYC + 1);
  localparam int DW = (HSE_DIV > 1) ? $clog2(HSE_DIV) : 1;

  logic          unlock_q;
  logic          on_q, rdy_q, byp_q, en_q, drst_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] start_cnt;
  logic [DW-1:0] div_cnt;
  logic          dom_wr, on_d, div_run, div_hit;
  logic          unused_bits;

  assign dom_wr  = wr_en && wr_dom && unlock_q;
  assign unused_bits = ^{wr_data[31:17], wr_data[14:10], wr_data[7:3], wr_data[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlock_q <= 1'b0;
    else if (wr_en && !wr_dom) unlock_q <= wr_data[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drst_q <= 1'b0;
      on_q   <= 1'b0;
      byp_q  <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= 2'd0;
    end else if (dom_wr) begin
      if (wr_data[16]) begin
        drst_q <= 1'b1;
        on_q   <= 1'b0;
        byp_q  <= 1'b0;
        en_q   <= 1'b0;
        sel_q  <= 2'd0;
      end else if (drst_q) begin
        drst_q <= 1'b0;
      end else begin
        on_q  <= wr_data[0];
        byp_q <= wr_data[2];
        en_q  <= wr_data[15];
        if (sel_q == 2'd0) sel_q <= wr_data[9:8];
      end
    end
  end

  assign on_d = dom_wr ? (!wr_data[16] && !drst_q && wr_data[0]) : on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_cnt <= '0;
      rdy_q     <= 1'b0;
    end else if (!on_d) begin
      start_cnt <= '0;
      rdy_q     <= 1'b0;
    end else if (on_q && !rdy_q) begin
      start_cnt <= start_cnt + 1'b1;
      rdy_q     <= (start_cnt == CW'(OSC_START_CYC - 1));
    end
  end

  assign div_run = en_q && (sel_q == 2'd3);
  assign div_hit = div_run && (div_cnt == DW'(HSE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (!div_run || div_hit) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    rtc_tick = 1'b0;
    if (en_q) begin
      case (sel_q)
        2'd1:    rtc_tick = rdy_q;
        2'd2:    rtc_tick = lsi_ready;
        2'd3:    rtc_tick = div_hit;
        default: rtc_tick = 1'b0;
      endcase
    end
  end

  assign dom_rd = {15'd0, drst_q, en_q, 5'd0, sel_q, 5'd0, byp_q, rdy_q, on_q};
  assign pwr_rd = {23'd0, unlock_q, 8'd0};

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dom && !unlock_q) |=> ($stable(sel_q) && $stable(en_q) && $stable(on_q)
                                        && $stable(byp_q) && $stable(drst_q)));

  assert_rdy_needs_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> on_q);

  assert_sel_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q != 2'd0) && !(dom_wr && wr_data[16])) |=> (sel_q == $past(sel_q)));

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drst_q |-> (sel_q == 2'd0 && !en_q && !on_q && !rdy_q && !byp_q));

  assert_tick_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |-> (en_q && sel_q != 2'd0));

  assert_div_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_hit |=> !div_hit);

endmodule

// File: tb/bkup_clk_ctl_tb.sv
module bkup_clk_ctl_tb;

  localparam int START = 16;
  localparam int DIV   = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_dom = 1'b0;
  logic [31:0] wr_data = '0;
  logic        lsi_ready = 1'b0;
  logic [31:0] dom_rd, pwr_rd;
  logic        rtc_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bkup_clk_ctl #(.OSC_START_CYC(START), .HSE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dom(wr_dom), .wr_data(wr_data),
    .lsi_ready(lsi_ready), .dom_rd(dom_rd), .pwr_rd(pwr_rd), .rtc_tick(rtc_tick)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic dom, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_dom = dom; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 dom_rd after reset", dom_rd, 32'h0);
    chk("R1 pwr_rd after reset", pwr_rd, 32'h0);
    chk("R1 tick after reset", {31'd0, rtc_tick}, 32'h0);
  endtask

  task automatic t_protect();
    wr(1'b1, 32'h0000_8101);
    chk("R2 locked write ignored", dom_rd, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    chk("R2 only unlock bit stored", pwr_rd, 32'h0000_0100);
    wr(1'b0, 32'h0000_0000);
    chk("R2 unlock cleared", pwr_rd, 32'h0);
    wr(1'b0, 32'h0000_0100);
  endtask

  task automatic t_fields();
    wr(1'b1, 32'hFFFE_FCFC & 32'h0000_8004);
    chk("R3 bypass and enable stored", dom_rd, 32'h0000_8004);
    wr(1'b1, 32'h0000_0002);
    chk("R4 ready bit not writable", dom_rd, 32'h0);
  endtask

  task automatic t_ready();
    wr(1'b1, 32'h0000_0001);
    cyc(START - 1);
    chk("R4 ready low one edge early", dom_rd, 32'h0000_0001);
    cyc(1);
    chk("R4 ready high at start count", dom_rd, 32'h0000_0003);
    wr(1'b1, 32'h0000_0000);
    chk("R5 ready cleared with osc off", dom_rd, 32'h0);
    wr(1'b1, 32'h0000_0001);
    cyc(START - 1);
    chk("R5 count restarted", dom_rd, 32'h0000_0001);
    cyc(1);
    wr(1'b1, 32'h0000_0000);
  endtask

  task automatic t_xtal_tick();
    wr(1'b1, 32'h0000_0101);
    chk("R8 tick low before ready", {31'd0, rtc_tick}, 32'h0);
    cyc(START);
    chk("R11 tick low with enable off", {31'd0, rtc_tick}, 32'h0);
    wr(1'b1, 32'h0000_8101);
    chk("R8 tick follows ready", {31'd0, rtc_tick}, 32'h1);
    wr(1'b1, 32'h0000_8201);
    chk("R6 select locked against 2", dom_rd, 32'h0000_8103);
    wr(1'b1, 32'h0000_8001);
    chk("R6 select locked against 0", dom_rd, 32'h0000_8103);
    wr(1'b1, 32'h0000_8100);
    chk("R8 tick drops with ready", {31'd0, rtc_tick}, 32'h0);
    chk("R5 ready cleared", dom_rd, 32'h0000_8100);
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'h0001_0000);
    chk("R2 locked reset ignored", dom_rd, 32'h0000_8100);
    wr(1'b0, 32'h0000_0100);
  endtask

  task automatic t_domain_reset();
    wr(1'b1, 32'h0000_8101);
    cyc(START);
    chk("R7 ready before reset", dom_rd, 32'h0000_8103);
    wr(1'b1, 32'h0001_0000);
    chk("R7 reset clears all fields", dom_rd, 32'h0001_0000);
    wr(1'b1, 32'h0000_8301);
    chk("R7 fields held while in reset", dom_rd, 32'h0000_0000);
    wr(1'b1, 32'h0000_8201);
    chk("R7 select writable after release", dom_rd, 32'h0000_8201);
    @(negedge clk); lsi_ready = 1'b1; #1;
    chk("R9 tick follows rc ready high", {31'd0, rtc_tick}, 32'h1);
    lsi_ready = 1'b0; #1;
    chk("R9 tick follows rc ready low", {31'd0, rtc_tick}, 32'h0);
  endtask

  task automatic t_divider();
    int ticks, first;
    wr(1'b1, 32'h0001_0000);
    wr(1'b1, 32'h0000_0000);
    wr(1'b1, 32'h0000_8300);
    ticks = 0; first = -1;
    for (int k = 1; k <= 4 * DIV; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rtc_tick) begin
        ticks++;
        if (first < 0) first = k;
      end
    end
    chk("R10 first divided tick", first, DIV - 1);
    chk("R10 ticks in four periods", ticks, 4);
    wr(1'b1, 32'h0000_0300);
    ticks = 0;
    for (int k = 0; k < 2 * DIV; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rtc_tick) ticks++;
    end
    chk("R11 no tick with enable off", ticks, 0);
    chk("R6 select 3 kept", dom_rd, 32'h0000_0300);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_fields();
    t_ready();
    t_xtal_tick();
    t_domain_reset();
    t_divider();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule